// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Slip-Based Word Framing

This block converts a serial bit stream into 8-bit parallel words and can move the bit boundary that frames each word. It runs in one clock domain. Every clock carries one serial bit. An internal bit counter marks every eighth clock as a word boundary, which stands in for the slower word clock. At each boundary the block presents one word and pulses a valid strobe for one cycle.

Link-training logic drives the slip request. During each word it looks at the parallel output. If the output is not the expected training pattern, it raises the slip request and the framing moves. The size of the step depends on the mode:
- Single-rate mode: each slip advances the framing by one bit.
- Double-rate mode: slips alternate between moving back by one bit and moving forward by three.

In both modes, eight slips on a pattern that repeats every 8 bits bring the framing back to where it started. The mode is captured while reset is held.

Top module: `deser_bitslip`

## Requirements
- R1: After reset, each word is built from 8 consecutive serial bits. The earliest bit goes to `wordOut[7]` and the latest to `wordOut[0]`, so a byte sent MSB-first comes out unchanged.
- R2: `wordValid` is low while reset is asserted. After reset it pulses high for exactly one cycle, once every 8 clocks. The first pulse follows the clock that captured the 8th serial bit after reset.
- R3: In single-rate mode (`ddrMode`=0 during reset), each accepted slip rotates later output words left by one bit. Example: a repeating pattern seen as 10010011 appears as 00100111 after one slip and as 01001110 after two.
- R4: In double-rate mode (`ddrMode`=1 during reset), accepted slips alternate between rotating right by one and rotating left by three. The first slip after reset rotates right by one. Example: 00100111 becomes 10010011 after one slip and 10011100 after two.
- R5: For a serial pattern that repeats every 8 bits, the eighth accepted slip returns the output to its initial framing. This holds in both modes.
- R6: `slipReq` is sampled only on the clock that captures the last bit of a word. A request on any other clock has no effect.
- R7: If `slipReq` stays high across several words, the block performs exactly one slip per word boundary.
- R8: A slip accepted at a boundary does not alter the word delivered at that same boundary. It applies from the next word on.
- R9: Reset returns the framing to its initial position, clears the double-rate alternation so that the next slip is right-by-one, and sets `wordOut` to zero.
- R10: `ddrMode` is captured only while reset is asserted. Changing it during operation has no effect on the slip steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset; also latches `ddrMode` |
| serIn | input | 1 | Serial data, one bit per clock |
| ddrMode | input | 1 | 0 = single-rate slip steps, 1 = double-rate alternating steps |
| slipReq | input | 1 | Slip request, sampled at word boundaries only |
| wordOut | output | 8 | Framed parallel word, earliest bit in the MSB |
| wordValid | output | 1 | One-cycle strobe marking a new `wordOut` |

## Verification
Two things can happen in the same cycle: a slip is accepted, and the word is loaded at that boundary. In that cycle the framing offset changes while the output register is capturing a word with the old framing.

The bench provokes this by raising `slipReq` exactly on the clock that carries the eighth bit of a word. It then checks two things:
- The word delivered at that boundary is still unrotated.
- The following word carries the new rotation.

Holding the request high through whole words checks the same collision again on consecutive boundaries.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // word boundary: capture framed word, pulse valid
    logic flush;  // clear history and output
  } ctrlStrobe_t;

  // Double-rate slip steps, in bit positions
  localparam int DDR_BACK_STEP = 1;
  localparam int DDR_FWD_STEP  = 3;
endpackage

// File: rtl/deser_ctrl.sv
`timescale 1ns/1ps
module deser_ctrl #(
  parameter int W = 8,
  localparam int OFF_W = $clog2(W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ddrMode,
  input  logic                    slipReq,
  output deser_pkg::ctrlStrobe_t  strobes,
  output logic [OFF_W-1:0]        offset
);
  import deser_pkg::*;

  logic [OFF_W-1:0] bitCnt;
  logic             ddrPhase;   // 0: next DDR slip steps back, 1: steps forward
  logic             modeDdr;    // mode captured during reset (R10)
  logic             wordEdge;
  logic             slipTaken;
  logic [OFF_W-1:0] stepNext;

  assign wordEdge  = (bitCnt == OFF_W'(W - 1));
  assign slipTaken = wordEdge && slipReq;   // R6, R7: one slip per boundary

  always_comb begin
    if (modeDdr) begin
      if (ddrPhase) stepNext = offset + OFF_W'(DDR_FWD_STEP);   // R4 left by three
      else          stepNext = offset - OFF_W'(DDR_BACK_STEP);  // R4 right by one
    end else begin
      stepNext = offset + OFF_W'(1);                             // R3 left by one
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      offset   <= '0;        // R9
      ddrPhase <= 1'b0;      // R9
      modeDdr  <= ddrMode;   // R10
    end else begin
      bitCnt <= bitCnt + OFF_W'(1);
      if (slipTaken) begin
        offset <= stepNext;
        if (modeDdr) ddrPhase <= ~ddrPhase;
      end
    end
  end

  assign strobes.load  = wordEdge && !rst;
  assign strobes.flush = rst;
endmodule

// File: rtl/deser_datapath.sv
`timescale 1ns/1ps
module deser_datapath #(
  parameter int W = 8,
  localparam int OFF_W  = $clog2(W),
  localparam int HIST_W = 2 * W - 2
) (
  input  logic                   clk,
  input  deser_pkg::ctrlStrobe_t strobes,
  input  logic [OFF_W-1:0]       offset,
  input  logic                   serIn,
  output logic [W-1:0]           wordOut,
  output logic                   wordValid
);
  logic [HIST_W-1:0] hist;      // older bits, newest in bit 0
  logic [HIST_W:0]   window;    // history plus the bit on the line now
  logic [OFF_W-1:0]  selBase;
  logic [W-1:0]      framed;

  assign window = {hist, serIn};
  // A left rotation by k picks the window that starts (W-k) mod W bits earlier
  assign selBase = OFF_W'(0) - offset;
  assign framed  = window[selBase +: W];

  always_ff @(posedge clk) begin
    if (strobes.flush) begin
      hist      <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      hist      <= window[HIST_W-1:0];
      wordValid <= strobes.load;            // R2
      if (strobes.load) wordOut <= framed;  // R1, R8: uses offset before update
    end
  end
endmodule

// File: rtl/deser_bitslip.sv
`timescale 1ns/1ps
module deser_bitslip #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         serIn,
  input  logic         ddrMode,
  input  logic         slipReq,
  output logic [W-1:0] wordOut,
  output logic         wordValid
);
  localparam int OFF_W = $clog2(W);

  deser_pkg::ctrlStrobe_t ctrlBus;
  logic [OFF_W-1:0]       offsetBus;

  deser_ctrl #(.W(W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .ddrMode (ddrMode),
    .slipReq (slipReq),
    .strobes (ctrlBus),
    .offset  (offsetBus)
  );

  deser_datapath #(.W(W)) uPath (
    .clk       (clk),
    .strobes   (ctrlBus),
    .offset    (offsetBus),
    .serIn     (serIn),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );
endmodule

// File: rtl/deser_bitslip_chk.sv
`timescale 1ns/1ps
module deser_bitslip_chk #(
  parameter int W = 8,
  localparam int OFF_W = $clog2(W)
) (
  input logic             clk,
  input logic             rst,
  input logic             ddrMode,
  input logic             slipReq,
  input logic             wordValid,
  input logic [W-1:0]     wordOut,
  input logic             tick,
  input logic [OFF_W-1:0] offset
);
  logic             chkDdr;
  logic [OFF_W+1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) chkDdr <= ddrMode;
  end

  always_ff @(posedge clk) begin
    if (rst)            gap <= '0;
    else if (wordValid) gap <= (OFF_W+2)'(1);
    else                gap <= gap + (OFF_W+2)'(1);
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> (gap == (OFF_W+2)'(W)));

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!wordValid && offset == '0));

  a_r8_word_held: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(wordOut));

  a_r3_sdr_step: assert property (@(posedge clk) disable iff (rst)
    (tick && slipReq && !chkDdr) |=> (offset == OFF_W'($past(offset) + OFF_W'(1))));

  a_r4_ddr_step: assert property (@(posedge clk) disable iff (rst)
    (tick && slipReq && chkDdr) |=>
      ((offset == OFF_W'($past(offset) - OFF_W'(1))) ||
       (offset == OFF_W'($past(offset) + OFF_W'(3)))));

  a_r6_no_slip_hold: assert property (@(posedge clk) disable iff (rst)
    !(tick && slipReq) |=> $stable(offset));
endmodule

bind deser_bitslip deser_bitslip_chk #(.W(W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .ddrMode   (ddrMode),
  .slipReq   (slipReq),
  .wordValid (wordValid),
  .wordOut   (wordOut),
  .tick      (ctrlBus.load),
  .offset    (offsetBus)
);

// File: tb/tb_deser_bitslip.sv
`timescale 1ns/1ps
module tb_deser_bitslip;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         serIn = 1'b0;
  logic         ddrMode = 1'b0;
  logic         slipReq = 1'b0;
  logic [W-1:0] wordOut;
  logic         wordValid;

  int   checks = 0;
  int   errors = 0;
  int   expOff = 0;
  logic expPhase = 1'b0;
  logic curDdr = 1'b0;

  always #5 clk = ~clk;

  deser_bitslip #(.W(W)) dut (
    .clk(clk), .rst(rst), .serIn(serIn), .ddrMode(ddrMode),
    .slipReq(slipReq), .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl(input logic [7:0] x, input int k);
    int kk = k % 8;
    return (x << kk) | (x >> (8 - kk));
  endfunction

  task automatic applySlip();
    if (curDdr) begin
      if (!expPhase) expOff = (expOff + 7) % 8;
      else           expOff = (expOff + 3) % 8;
      expPhase = ~expPhase;
    end else begin
      expOff = (expOff + 1) % 8;
    end
  endtask

  task automatic doReset(input logic ddr);
    @(negedge clk);
    rst = 1'b1; ddrMode = ddr; slipReq = 1'b0; serIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(wordValid == 1'b0, "R2 valid low in reset", 8'(wordValid), 8'h00);
    chk(wordOut == 8'h00, "R9 output cleared", wordOut, 8'h00);
    rst = 1'b0;
    curDdr = ddr; expOff = 0; expPhase = 1'b0;
  endtask

  // slipBit: -1 none, 0..7 pulse on that bit, 8 held for the whole word
  task automatic sendWord(input logic [7:0] pat, input int slipBit,
                          output logic [7:0] got, output logic gotValid, output int midHigh);
    midHigh = 0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) begin
        @(negedge clk);
        if (wordValid) midHigh++;
      end
      serIn   = pat[7 - i];
      slipReq = (slipBit == 8) || (slipBit == i);
      @(posedge clk);
    end
    #1;
    got = wordOut;
    gotValid = wordValid;
  endtask

  task automatic wordStep(input logic [7:0] pat, input int slipBit, input string tag,
                          output logic [7:0] got);
    logic v;
    int   mid;
    logic [7:0] exp;
    exp = rotl(pat, expOff);
    sendWord(pat, slipBit, got, v, mid);
    chk(v == 1'b1, {tag, " R2 valid at boundary"}, 8'(v), 8'h01);
    chk(mid == 0, {tag, " R2 valid low inside word"}, 8'(mid), 8'h00);
    chk(got == exp, tag, got, exp);
    if (slipBit == 7 || slipBit == 8) applySlip();
  endtask

  task automatic testReset();
    doReset(1'b0);
  endtask

  task automatic testAssembly();
    logic [7:0] g;
    doReset(1'b0);
    wordStep(8'hA5, -1, "R1 word A5", g);
    wordStep(8'h3C, -1, "R1 word 3C", g);
    wordStep(8'hF0, -1, "R1 word F0", g);
    wordStep(8'h01, -1, "R1 word 01", g);
  endtask

  task automatic testSdr();
    logic [7:0] g;
    doReset(1'b0);
    wordStep(8'h93, -1, "R1 sdr prime", g);
    wordStep(8'h93, 7, "R8 slip word unchanged", g);
    chk(g == 8'h93, "R8 same-boundary word", g, 8'h93);
    wordStep(8'h93, 7, "R3 first slip", g);
    chk(g == 8'h27, "R3 after one slip", g, 8'h27);
    wordStep(8'h93, 7, "R3 second slip", g);
    chk(g == 8'h4E, "R3 after two slips", g, 8'h4E);
    for (int n = 3; n < 8; n++) wordStep(8'h93, 7, "R3 sdr sweep", g);
    wordStep(8'h93, -1, "R5 sdr wrap", g);
    chk(g == 8'h93, "R5 sdr back to initial", g, 8'h93);
  endtask

  task automatic testDdr();
    logic [7:0] g;
    doReset(1'b1);
    wordStep(8'h27, -1, "R4 ddr prime", g);
    wordStep(8'h27, 7, "R8 ddr slip word unchanged", g);
    wordStep(8'h27, 7, "R4 first slip", g);
    chk(g == 8'h93, "R4 after one slip right by one", g, 8'h93);
    wordStep(8'h27, 7, "R4 second slip", g);
    chk(g == 8'h9C, "R4 after two slips left by three", g, 8'h9C);
    for (int n = 3; n < 8; n++) wordStep(8'h27, 7, "R4 ddr sweep", g);
    wordStep(8'h27, -1, "R5 ddr wrap", g);
    chk(g == 8'h27, "R5 ddr back to initial", g, 8'h27);
  endtask

  task automatic testMidIgnored();
    logic [7:0] g;
    doReset(1'b0);
    wordStep(8'h93, -1, "R6 prime", g);
    wordStep(8'h93, 3, "R6 pulse bit3", g);
    wordStep(8'h93, 0, "R6 pulse bit0", g);
    wordStep(8'h93, 6, "R6 pulse bit6", g);
    wordStep(8'h93, -1, "R6 after pulses", g);
    chk(g == 8'h93, "R6 mid-word requests ignored", g, 8'h93);
  endtask

  task automatic testHeld();
    logic [7:0] g;
    doReset(1'b0);
    wordStep(8'h93, -1, "R7 prime", g);
    for (int n = 0; n < 3; n++) wordStep(8'h93, 8, "R7 held request", g);
    wordStep(8'h93, -1, "R7 after hold", g);
    chk(g == 8'h9C, "R7 three words held gives three slips", g, 8'h9C);
  endtask

  task automatic testResetClears();
    logic [7:0] g;
    doReset(1'b1);
    wordStep(8'h27, -1, "R9 prime", g);
    wordStep(8'h27, 7, "R9 pre slip", g);
    wordStep(8'h27, -1, "R9 slipped", g);
    doReset(1'b1);
    wordStep(8'h27, 7, "R9 first word after reset", g);
    chk(g == 8'h27, "R9 framing restored", g, 8'h27);
    wordStep(8'h27, -1, "R9 phase cleared", g);
    chk(g == 8'h93, "R9 next ddr slip is right by one", g, 8'h93);
  endtask

  task automatic testModeLatch();
    logic [7:0] g;
    doReset(1'b0);
    ddrMode = 1'b1;
    wordStep(8'h27, -1, "R10 prime", g);
    wordStep(8'h27, 7, "R10 slip", g);
    wordStep(8'h27, -1, "R10 sdr kept", g);
    chk(g == 8'h4E, "R10 mode change ignored, sdr step", g, 8'h4E);
    doReset(1'b1);
    ddrMode = 1'b0;
    wordStep(8'h27, -1, "R10 prime ddr", g);
    wordStep(8'h27, 7, "R10 slip ddr", g);
    wordStep(8'h27, -1, "R10 ddr kept", g);
    chk(g == 8'h93, "R10 mode change ignored, ddr step", g, 8'h93);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testAssembly();
    testSdr();
    testDdr();
    testMidIgnored();
    testHeld();
    testResetClears();
    testModeLatch();
    finishRun();
  end
endmodule